// File: doc/BRIEF.md
# Packed Byte Lane Unpacker

The unpacker sits after a memory load port. It takes a group of consecutive bytes and widens each one into its own 16-bit lane of a packed result. A narrow request uses two bytes and gives a 32-bit word. A wide request uses four bytes and gives a 64-bit doubleword.

Each lane is filled in one of two ways:
- **Zero fill:** the upper half of the lane is cleared.
- **Sign fill:** the upper half of the lane repeats bit 7 of that lane's byte.

A control module registers the valid strobe and decodes the request into a small set of strobes. A datapath module builds and registers the lanes. Results appear one clock after the request.

Top module: `byteUnpackTop`

## Requirements
- R1: Synchronous active-low reset clears outValid and outData to zero.
- R2: outValid equals the inValid of the previous clock cycle, so a result follows its request by one cycle.
- R3: The byte at inBytes[7:0] (lowest address) lands in outData[7:0]. Byte k (inBytes[8k+7:8k]) lands in outData[16k+7:16k].
- R4: With isSigned=0, bits 15:8 of every active lane are zero. For example, bytes 0x81,0x02 give 0x00020081.
- R5: With isSigned=1, bits 15:8 of each active lane copy bit 7 of that lane's byte. For example, bytes 0x81,0x02 give 0x0002FF81.
- R6: With wideMode=1, four bytes fill four lanes into a 64-bit result. For example, signed bytes 0x81,0x02,0x83,0x04 give 0x0004FF830002FF81.
- R7: With wideMode=0, only two lanes are active. outData[63:32] is zero, and inBytes[63:16] has no effect on the output.
- R8: When inValid=0, outData keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| inValid | input | 1 | Request strobe |
| wideMode | input | 1 | 0: two lanes (32-bit), 1: four lanes (64-bit) |
| isSigned | input | 1 | 0: zero fill, 1: sign fill |
| inBytes | input | 64 | Loaded bytes, lowest address in bits 7:0 |
| outValid | output | 1 | Registered valid |
| outData | output | 64 | Registered packed result |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, 16-bit lanes and up to four lanes. These give the full 64-bit output, so the wide four-lane form and the narrow two-lane form can both be checked.

The test patterns are chosen to expose the fill behaviour:
- Bytes with bit 7 set and clear alternate, so zero and sign fill give different results in every lane.
- In narrow requests the upper input bytes are loaded with non-zero values, to show they are ignored.
- Idle cycles between requests show that the output is held.

// File: rtl/byteUnpackPkg.sv
package byteUnpackPkg;
  localparam int ByteW = 8;
  localparam int LaneW = 16;
  localparam int MaxLanes = 4;
  localparam int NarrowLanes = 2;
  localparam int InW = ByteW * MaxLanes;
  localparam int OutW = LaneW * MaxLanes;

  typedef struct packed {
    logic load;
    logic signFill;
    logic [MaxLanes-1:0] laneEn;
  } unpackCtrl_t;
endpackage

// File: rtl/byteUnpackCtrl.sv
module byteUnpackCtrl
  import byteUnpackPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        wideMode,
  input  logic        isSigned,
  output unpackCtrl_t ctrl,
  output logic        validQ
);
  logic [MaxLanes-1:0] laneMask;

  // One enable bit per lane: narrow requests enable the low lanes only,
  // wide requests enable all of them.
  generate
    for (genvar k = 0; k < MaxLanes; k++) begin : gMask
      if (k < NarrowLanes) begin : gLow
        assign laneMask[k] = 1'b1;
      end else begin : gHigh
        assign laneMask[k] = wideMode;
      end
    end
  endgenerate

  always_comb begin
    ctrl.load     = inValid;
    ctrl.signFill = isSigned;
    ctrl.laneEn   = laneMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= inValid;
  end
endmodule

// File: rtl/byteUnpackData.sv
module byteUnpackData
  import byteUnpackPkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  unpackCtrl_t     ctrl,
  input  logic [InW-1:0]  inBytes,
  output logic [OutW-1:0] dataQ
);
  logic [OutW-1:0] laneNext;

  // Each lane widens one byte. The upper half is either zero or
  // copies of the byte's bit 7, and an inactive lane is zero.
  generate
    for (genvar k = 0; k < MaxLanes; k++) begin : gLane
      logic [ByteW-1:0] b;
      logic fillBit;
      assign b = inBytes[k*ByteW +: ByteW];
      assign fillBit = ctrl.signFill & b[ByteW-1];
      assign laneNext[k*LaneW +: LaneW] =
        ctrl.laneEn[k] ? {{(LaneW-ByteW){fillBit}}, b} : '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)          dataQ <= '0;
    else if (ctrl.load) dataQ <= laneNext;
  end
endmodule

// File: rtl/byteUnpackTop.sv
module byteUnpackTop
  import byteUnpackPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        wideMode,
  input  logic        isSigned,
  input  logic [63:0] inBytes,
  output logic        outValid,
  output logic [63:0] outData
);
  unpackCtrl_t ctrl;
  logic [OutW-1:0] dataQ;

  byteUnpackCtrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .wideMode(wideMode),
    .isSigned(isSigned), .ctrl(ctrl), .validQ(outValid)
  );

  byteUnpackData uData (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .inBytes(inBytes[InW-1:0]),
    .dataQ(dataQ)
  );

  assign outData = dataQ;

  // Only the low InW bits of inBytes carry byte data.
  logic unusedHi;
  assign unusedHi = ^inBytes[63:InW];
endmodule

// File: rtl/byteUnpackChk.sv
module byteUnpackChk (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic        wideMode,
  input logic        isSigned,
  input logic [63:0] inBytes,
  input logic        outValid,
  input logic [63:0] outData
);
  AST_RESET_CLEAR: assert property (@(posedge clk) !rstN |=> (!outValid && outData == 64'h0)); // R1
  AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rstN) $past(rstN) |-> outValid == $past(inValid)); // R2
  AST_LOW_BYTE: assert property (@(posedge clk) disable iff (!rstN) inValid |=> outData[7:0] == $past(inBytes[7:0])); // R3
  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rstN) (inValid && !isSigned) |=> (outData[15:8] == 8'h0 && outData[31:24] == 8'h0)); // R4
  AST_SIGN_FILL: assert property (@(posedge clk) disable iff (!rstN) (inValid && isSigned) |=> outData[15:8] == {8{$past(inBytes[7])}}); // R5
  AST_WIDE_TOP: assert property (@(posedge clk) disable iff (!rstN) (inValid && wideMode) |=> outData[55:48] == $past(inBytes[31:24])); // R6
  AST_NARROW_HIGH: assert property (@(posedge clk) disable iff (!rstN) (inValid && !wideMode) |=> outData[63:32] == 32'h0); // R7
  AST_HOLD: assert property (@(posedge clk) disable iff (!rstN) ($past(rstN) && !inValid) |=> $stable(outData)); // R8
endmodule

bind byteUnpackTop byteUnpackChk i_chk (.*);

// File: tb/test_byteUnpackTop.sv
`timescale 1ns/1ps
module test_byteUnpackTop;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic wideMode = 1'b0;
  logic isSigned = 1'b0;
  logic [63:0] inBytes = '0;
  logic outValid;
  logic [63:0] outData;
  int nChk = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  byteUnpackTop i_byteUnpackTop (.*);

  // Vector fields: {wideMode, isSigned, inBytes, expected outData}
  localparam int NV = 8;
  localparam logic [129:0] VEC [NV] = '{
    {1'b0, 1'b0, 64'h0000_0000_0000_0281, 64'h0000_0000_0002_0081},
    {1'b0, 1'b1, 64'h0000_0000_0000_0281, 64'h0000_0000_0002_FF81},
    {1'b1, 1'b1, 64'h0000_0000_0483_0281, 64'h0004_FF83_0002_FF81},
    {1'b1, 1'b0, 64'h0000_0000_0483_0281, 64'h0004_0083_0002_0081},
    {1'b0, 1'b1, 64'hDEAD_BEEF_CAFE_7F80, 64'h0000_0000_007F_FF80},
    {1'b1, 1'b1, 64'h1111_2222_8A09_8887, 64'hFF8A_0009_FF88_FF87},
    {1'b1, 1'b0, 64'h0000_0000_FFFF_FFFF, 64'h00FF_00FF_00FF_00FF},
    {1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_0000, 64'h0000_0000_0000_0000}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset valid", {63'h0, outValid}, 64'h0);
    check("R1 reset data", outData, 64'h0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {wideMode, isSigned, inBytes} = VEC[i][129:64];
      inValid = 1'b1;
      @(negedge clk);
      inValid = 1'b0;
      check("R2 valid", {63'h0, outValid}, 64'h1);
      check("R3/R4/R5/R6/R7 data", outData, VEC[i][63:0]);
    end

    // R8: hold with a changed input while idle
    @(negedge clk);
    inBytes = 64'h1234_5678_9ABC_DEF0;
    wideMode = 1'b1;
    @(negedge clk);
    check("R8 hold", outData, 64'h0);
    check("R2 idle valid", {63'h0, outValid}, 64'h0);

    // R7: upper input bytes ignored in narrow mode
    @(negedge clk);
    wideMode = 1'b0; isSigned = 1'b1;
    inBytes = 64'h8080_8080_8080_0102;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check("R7 narrow upper", outData, 64'h0000_0000_0001_0002);

    // R1: reset mid-run clears a loaded result
    @(negedge clk);
    inValid = 1'b1; wideMode = 1'b1;
    @(negedge clk);
    inValid = 1'b0; rstN = 1'b0;
    @(negedge clk);
    check("R1 reset data mid", outData, 64'h0);
    check("R1 reset valid mid", {63'h0, outValid}, 64'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule